// File: doc/BRIEF.md
# Accumulator CPU core

A small multi-cycle processor that works on 8-bit data. It keeps an accumulator, an 8-bit program counter, an instruction register, a bank of general registers and three status flags (zero, carry, negative). It fetches one-byte instructions from a single synchronous 256-byte memory that holds both code and data. Each instruction then passes through fixed fetch, decode and execute phases. The memory interface is one address bus, separate read and write data buses, and one read and one write strobe. All of these come straight from registers.

Every instruction byte splits into an upper opcode nibble and a lower operand nibble. For register opcodes the operand picks a general register. For memory and jump opcodes it is an address in the lowest 16 bytes of memory. A program that needs data in that window usually starts with a jump over it.

An external pause input acts as a clock enable. While it is high, nothing in the core changes, and the core resumes exactly where it stopped. A halt opcode parks the core until the next reset.

Top module: `acc8_core`

## Requirements
- R1: While reset is high the accumulator, flags, PC, instruction register, all general registers and both strobes are cleared and halted_o is low. The first read strobe after reset is released appears one cycle later, with address 0.
- R2: Opcodes, in the upper nibble, with n as the lower nibble:
  - 0x1n ADD: accumulator plus Rn.
  - 0x2n SUB: accumulator minus Rn.
  - 0x3n AND, 0x4n OR, 0x5n XOR: accumulator combined with Rn.
  - 0x6 NOT, 0x7 INC, 0x8 DEC: act on the accumulator alone.
  - 0x9n load the accumulator from address n; 0xAn store the accumulator to address n.
  - 0xBn jump to address n.
  - 0xCn copy the accumulator into Rn; 0xDn copy Rn into the accumulator.
  - 0x0 and 0xE do nothing; 0xF halts.
- R3: Instruction fetch drives the PC onto the address bus with the read strobe. The PC then advances by one, so code runs from consecutive addresses.
- R4: ADD, SUB, INC and DEC set C to the carry out of a two's-complement addition. For SUB and DEC, C=1 means no borrow. Z is set when the result is 0 and N takes result bit 7. In flags_o, bit 0 is Z, bit 1 is C and bit 2 is N.
- R5: AND, OR, XOR and NOT set Z and N from the result and clear C.
- R6: Load (0x9n) reads memory address n into the accumulator. Loads, register copies, stores, jumps and no-ops leave the flags unchanged.
- R7: Store (0xAn) writes the accumulator to address n. The write strobe lasts one cycle, its data equals the accumulator, and read and write are never asserted together.
- R8: Jump (0xBn) makes the next fetch come from address n. The bytes skipped over are not executed.
- R9: After 0xF is executed, halted_o stays high with both strobes low until reset.
- R10: While halt_i is high, no register or output changes. After halt_i drops, execution continues as if the paused edges had never happened.
- R11: The gap from one fetch read to the next is 5 cycles for every opcode except load, which takes 6. A halt at address 0 raises halted_o after the fifth clock edge following reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_i | input | 1 | Pause: freezes all state while high |
| mem_addr_o | output | 8 | Memory address, registered |
| mem_rd_o | output | 1 | Read strobe; the memory returns data on the next cycle |
| mem_wr_o | output | 1 | Write strobe, one cycle per store |
| mem_wdata_o | output | 8 | Store data |
| mem_rdata_i | input | 8 | Read data from the synchronous memory |
| acc_o | output | 8 | Accumulator value |
| flags_o | output | 3 | {N, C, Z} |
| halted_o | output | 1 | High once the halt opcode has executed |

## Verification
The bench runs short programs against a reference model of each operation. It drives carry and borrow across their edges: 0xFF+1, 0-1, equal operands for SUB, and results that land exactly on 0x80. A core with an inverted borrow sense, or one that leaves C set after a logic operation, shows up as a wrong flag word. Before each logic operation the flags are deliberately left with carry set, so a stale flag is caught.

Pausing the core mid-loop must end with the same accumulator and bus state as an unpaused run of equal active length. A core that lets any register slip while paused drifts from that result.

The bench also counts cycles between fetches and after a halt. An extra or missing wait state, a skipped jump target, or a halt that leaks further reads is visible at the ports.

// File: rtl/acc8_pkg.sv
package acc8_pkg;

  localparam int OPC_W  = 4;
  localparam int OPND_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP   = 4'h0,
    OP_ADD   = 4'h1,
    OP_SUB   = 4'h2,
    OP_AND   = 4'h3,
    OP_OR    = 4'h4,
    OP_XOR   = 4'h5,
    OP_NOT   = 4'h6,
    OP_INC   = 4'h7,
    OP_DEC   = 4'h8,
    OP_LDA   = 4'h9,
    OP_STA   = 4'hA,
    OP_JMP   = 4'hB,
    OP_STR   = 4'hC,
    OP_LDR   = 4'hD,
    OP_SPARE = 4'hE,
    OP_HLT   = 4'hF
  } opcode_e;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_XOR,
    ALU_NOT,
    ALU_INC,
    ALU_DEC
  } alu_op_e;

  typedef enum logic [2:0] {
    PH_FETCH,
    PH_FWAIT,
    PH_LOADIR,
    PH_DECODE,
    PH_EXEC,
    PH_MEM,
    PH_MEMRD,
    PH_HALT
  } phase_e;

  typedef struct packed {
    logic n;
    logic c;
    logic z;
  } flags_t;

  typedef struct packed {
    logic    fetch;
    logic    strobe_clr;
    logic    ir_load;
    logic    mem_rd_set;
    logic    mem_wr_set;
    logic    alu_we;
    logic    acc_mem;
    logic    acc_reg;
    logic    reg_we;
    logic    pc_jump;
    logic    halted;
    alu_op_e alu_op;
  } ctrl_t;

  function automatic alu_op_e opc_to_alu(input opcode_e opc);
    case (opc)
      OP_SUB:  return ALU_SUB;
      OP_AND:  return ALU_AND;
      OP_OR:   return ALU_OR;
      OP_XOR:  return ALU_XOR;
      OP_NOT:  return ALU_NOT;
      OP_INC:  return ALU_INC;
      OP_DEC:  return ALU_DEC;
      default: return ALU_ADD;
    endcase
  endfunction

  function automatic logic is_alu(input opcode_e opc);
    return (opc >= OP_ADD) && (opc <= OP_DEC);
  endfunction

endpackage

// File: rtl/acc8_alu.sv
module acc8_alu
  import acc8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o,
  output logic              c_o
);

  logic [DATA_W-1:0] b_mod;
  logic              cin;
  logic              arith;
  logic [DATA_W:0]   sum;

  // One shared adder: operand B is passed, inverted, forced to zero or to
  // all ones, and the carry-in picks the +1 needed for two's complement.
  always_comb begin
    b_mod = b_i;
    cin   = 1'b0;
    arith = 1'b1;
    case (op_i)
      ALU_ADD: b_mod = b_i;
      ALU_SUB: begin b_mod = ~b_i; cin = 1'b1; end
      ALU_INC: begin b_mod = '0;   cin = 1'b1; end
      ALU_DEC: begin b_mod = '1;   cin = 1'b0; end
      default: arith = 1'b0;
    endcase
    sum = {1'b0, a_i} + {1'b0, b_mod} + {{DATA_W{1'b0}}, cin};
  end

  always_comb begin
    case (op_i)
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_XOR: y_o = a_i ^ b_i;
      ALU_NOT: y_o = ~a_i;
      default: y_o = sum[DATA_W-1:0];
    endcase
    c_o = arith & sum[DATA_W];
  end

endmodule

// File: rtl/acc8_regs.sv
module acc8_regs #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16,
  localparam int SEL_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] bank [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) bank[i] <= '0;
    end else if (en && we) begin
      bank[sel_i] <= wdata_i;
    end
  end

  assign rdata_o = bank[sel_i];

endmodule

// File: rtl/acc8_ctrl.sv
module acc8_ctrl
  import acc8_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [OPC_W-1:0] opc_i,
  output ctrl_t            ctl_o
);

  phase_e  st, st_nx;
  opcode_e opc;

  assign opc = opcode_e'(opc_i);

  always_ff @(posedge clk) begin
    if (rst)     st <= PH_FETCH;
    else if (en) st <= st_nx;
  end

  always_comb begin
    ctl_o        = '0;
    ctl_o.alu_op = opc_to_alu(opc);
    st_nx        = st;
    case (st)
      PH_FETCH: begin
        ctl_o.fetch = 1'b1;
        st_nx       = PH_FWAIT;
      end
      PH_FWAIT: begin
        ctl_o.strobe_clr = 1'b1;
        st_nx            = PH_LOADIR;
      end
      PH_LOADIR: begin
        ctl_o.ir_load = 1'b1;
        st_nx         = PH_DECODE;
      end
      PH_DECODE: begin
        case (opc)
          OP_LDA: begin ctl_o.mem_rd_set = 1'b1; st_nx = PH_MEM; end
          OP_STA: begin ctl_o.mem_wr_set = 1'b1; st_nx = PH_MEM; end
          default: st_nx = PH_EXEC;
        endcase
      end
      PH_EXEC: begin
        st_nx = PH_FETCH;
        if (is_alu(opc)) ctl_o.alu_we = 1'b1;
        case (opc)
          OP_STR:  ctl_o.reg_we  = 1'b1;
          OP_LDR:  ctl_o.acc_reg = 1'b1;
          OP_JMP:  ctl_o.pc_jump = 1'b1;
          OP_HLT:  st_nx         = PH_HALT;
          default: ;
        endcase
      end
      PH_MEM: begin
        ctl_o.strobe_clr = 1'b1;
        st_nx            = (opc == OP_LDA) ? PH_MEMRD : PH_FETCH;
      end
      PH_MEMRD: begin
        ctl_o.acc_mem = 1'b1;
        st_nx         = PH_FETCH;
      end
      PH_HALT: ctl_o.halted = 1'b1;
      default: st_nx = PH_FETCH;
    endcase
  end

endmodule

// File: rtl/acc8_core.sv
module acc8_core
  import acc8_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] acc_o,
  output logic [2:0]        flags_o,
  output logic              halted_o
);

  localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic              en;
  ctrl_t             ctl;
  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] ir;
  logic [DATA_W-1:0] acc;
  flags_t            flg;
  logic [OPND_W-1:0] opnd;
  logic [OPC_W-1:0]  opc;
  logic [DATA_W-1:0] gpr_q;
  logic [DATA_W-1:0] alu_y;
  logic              alu_c;

  assign en   = ~halt_i;
  assign opc  = ir[DATA_W-1 -: OPC_W];
  assign opnd = ir[OPND_W-1:0];

  acc8_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .opc_i (opc),
    .ctl_o (ctl)
  );

  acc8_regs #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .we      (ctl.reg_we),
    .sel_i   (opnd[SEL_W-1:0]),
    .wdata_i (acc),
    .rdata_o (gpr_q)
  );

  acc8_alu #(
    .DATA_W (DATA_W)
  ) u_alu (
    .op_i (ctl.alu_op),
    .a_i  (acc),
    .b_i  (gpr_q),
    .y_o  (alu_y),
    .c_o  (alu_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc          <= '0;
      ir          <= '0;
      acc         <= '0;
      flg         <= '0;
      mem_addr_o  <= '0;
      mem_rd_o    <= 1'b0;
      mem_wr_o    <= 1'b0;
      mem_wdata_o <= '0;
    end else if (en) begin
      if (ctl.fetch) begin
        mem_addr_o <= pc;
        mem_rd_o   <= 1'b1;
      end
      if (ctl.strobe_clr) begin
        mem_rd_o <= 1'b0;
        mem_wr_o <= 1'b0;
      end
      if (ctl.ir_load) begin
        ir <= mem_rdata_i;
        pc <= pc + 1'b1;
      end
      if (ctl.mem_rd_set) begin
        mem_addr_o <= ADDR_W'(opnd);
        mem_rd_o   <= 1'b1;
      end
      if (ctl.mem_wr_set) begin
        mem_addr_o  <= ADDR_W'(opnd);
        mem_wdata_o <= acc;
        mem_wr_o    <= 1'b1;
      end
      if (ctl.alu_we) begin
        acc   <= alu_y;
        flg.z <= (alu_y == '0);
        flg.c <= alu_c;
        flg.n <= alu_y[DATA_W-1];
      end
      if (ctl.acc_mem) acc <= mem_rdata_i;
      if (ctl.acc_reg) acc <= gpr_q;
      if (ctl.pc_jump) pc  <= ADDR_W'(opnd);
    end
  end

  assign acc_o    = acc;
  assign flags_o  = flg;
  assign halted_o = ctl.halted;

endmodule

// File: rtl/acc8_core_chk.sv
module acc8_core_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              halt_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic [DATA_W-1:0] acc_o,
  input logic [2:0]        flags_o,
  input logic              halted_o
);

  // R1: the cycle after a reset edge shows the cleared state
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (acc_o == '0 && flags_o == '0 && !halted_o && !mem_wr_o));

  // R7: strobes never overlap
  p_rd_wr_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_o && mem_wr_o));

  // R7: one write cycle per store
  p_wr_single_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_o && !halt_i) |=> !mem_wr_o);

  // R7: store data equals the accumulator
  p_wdata_acc_r7: assert property (@(posedge clk) disable iff (rst)
    mem_wr_o |-> (mem_wdata_o == acc_o));

  // R9: halted is sticky
  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    halted_o |=> halted_o);

  // R9: no memory traffic once halted
  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    halted_o |-> (!mem_rd_o && !mem_wr_o));

  // R10: a paused edge changes nothing
  p_freeze_r10: assert property (@(posedge clk) disable iff (rst)
    halt_i |=> ($stable(acc_o) && $stable(flags_o) && $stable(mem_addr_o) &&
                $stable(mem_rd_o) && $stable(mem_wr_o) && $stable(halted_o)));

endmodule

bind acc8_core acc8_core_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .halt_i      (halt_i),
  .mem_addr_o  (mem_addr_o),
  .mem_rd_o    (mem_rd_o),
  .mem_wr_o    (mem_wr_o),
  .mem_wdata_o (mem_wdata_o),
  .acc_o       (acc_o),
  .flags_o     (flags_o),
  .halted_o    (halted_o)
);

// File: tb/acc8_core_bench.sv
module acc8_core_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       halt_i = 1'b0;
  logic [7:0] mem_addr_o;
  logic       mem_rd_o;
  logic       mem_wr_o;
  logic [7:0] mem_wdata_o;
  logic [7:0] mem_rdata_i = '0;
  logic [7:0] acc_o;
  logic [2:0] flags_o;
  logic       halted_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  logic [7:0] mem [256];

  always #10 clk = ~clk;

  acc8_core u_acc8_core (
    .clk         (clk),
    .rst         (rst),
    .halt_i      (halt_i),
    .mem_addr_o  (mem_addr_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .acc_o       (acc_o),
    .flags_o     (flags_o),
    .halted_o    (halted_o)
  );

  always @(posedge clk) begin
    if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];
    if (mem_wr_o) mem[mem_addr_o] <= mem_wdata_o;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run did not finish act=%0d exp<=150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Put the core in reset and clear memory; the caller then pokes a program.
  task automatic begin_prog();
    @(negedge clk);
    rst    = 1'b1;
    halt_i = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  task automatic go();
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_to_halt(output int n, output int wrs, output int rds_after);
    n = 0; wrs = 0; rds_after = 0;
    while (!halted_o && n < 2000) begin
      @(negedge clk);
      n = n + 1;
      if (mem_wr_o) wrs = wrs + 1;
    end
  endtask

  // Expected {flags, acc} from the operation definitions (R4, R5, R6)
  function automatic logic [10:0] model(input logic [7:0] x, input logic [7:0] y,
                                        input logic [7:0] ins, input logic [2:0] fin);
    logic [7:0] r;
    logic       c;
    logic [2:0] f;
    r = x; c = 1'b0; f = fin;
    case (ins[7:4])
      4'h1: begin r = x + y; c = (int'(x) + int'(y)) > 255; end
      4'h2: begin r = x - y; c = (x >= y); end
      4'h3: r = x & y;
      4'h4: r = x | y;
      4'h5: r = x ^ y;
      4'h6: r = ~x;
      4'h7: begin r = x + 8'd1; c = (x == 8'hFF); end
      4'h8: begin r = x - 8'd1; c = (x != 8'h00); end
      4'hD: r = y;
      default: r = x;
    endcase
    if (ins[7:4] >= 4'h1 && ins[7:4] <= 4'h8) f = {r[7], c, (r == 8'h00)};
    return {f, r};
  endfunction

  // Program: R3=y, acc=x with carry preset (flags 011), then one instruction.
  task automatic run_op(input logic [7:0] x, input logic [7:0] y, input logic [7:0] ins,
                        input string req);
    int n, w, r;
    logic [10:0] e;
    begin_prog();
    mem[0]  = 8'hB8;
    mem[1]  = x;
    mem[2]  = y;
    mem[4]  = 8'hFF;
    mem[8]  = 8'h94;
    mem[9]  = 8'h70;
    mem[10] = 8'h92;
    mem[11] = 8'hC3;
    mem[12] = 8'h91;
    mem[13] = ins;
    mem[14] = 8'hF0;
    go();
    run_to_halt(n, w, r);
    e = model(x, y, ins, 3'b011);
    chk({req, " acc"},   32'(acc_o),   32'(e[7:0]));
    chk({req, " flags"}, 32'(flags_o), 32'(e[10:8]));
  endtask

  task automatic t_reset();
    int n, w, r;
    begin_prog();
    mem[0] = 8'h90; mem[1] = 8'hC9; mem[2] = 8'h70; mem[3] = 8'hF0;
    go();
    run_to_halt(n, w, r);
    chk("R2 setup acc", 32'(acc_o), 32'h91);
    begin_prog();
    chk("R1 acc in reset",    32'(acc_o),    32'h0);
    chk("R1 flags in reset",  32'(flags_o),  32'h0);
    chk("R1 halted in reset", 32'(halted_o), 32'h0);
    chk("R1 strobes in reset", 32'({mem_rd_o, mem_wr_o}), 32'h0);
    mem[0] = 8'h19; mem[1] = 8'hF0;
    go();
    @(negedge clk);
    chk("R1 first fetch addr", 32'(mem_addr_o), 32'h0);
    chk("R1 first fetch rd",   32'(mem_rd_o),   32'h1);
    run_to_halt(n, w, r);
    chk("R1 R9 cleared acc", 32'(acc_o),   32'h0);
    chk("R1 zero flag",      32'(flags_o), 32'h1);
  endtask

  task automatic t_fetch();
    int n, w, r;
    begin_prog();
    mem[2] = 8'hF0;
    go();
    @(negedge clk);
    chk("R3 fetch0 addr", 32'(mem_addr_o), 32'h0);
    @(negedge clk);
    chk("R3 read strobe one cycle", 32'(mem_rd_o), 32'h0);
    repeat (4) @(negedge clk);
    chk("R3 R11 second fetch addr", 32'(mem_addr_o), 32'h1);
    chk("R11 second fetch rd",      32'(mem_rd_o),   32'h1);
    run_to_halt(n, w, r);
    chk("R11 cycles to halt", 32'(n), 32'd9);
  endtask

  task automatic t_alu();
    logic [23:0] v [20];
    v[0]  = {8'h05, 8'h03, 8'h13};  v[1]  = {8'hF0, 8'h20, 8'h13};
    v[2]  = {8'hFF, 8'h01, 8'h13};  v[3]  = {8'h40, 8'h40, 8'h13};
    v[4]  = {8'h09, 8'h05, 8'h23};  v[5]  = {8'h05, 8'h09, 8'h23};
    v[6]  = {8'h07, 8'h07, 8'h23};  v[7]  = {8'hFF, 8'h00, 8'h70};
    v[8]  = {8'h7F, 8'h00, 8'h70};  v[9]  = {8'h00, 8'h00, 8'h80};
    v[10] = {8'h01, 8'h00, 8'h80};  v[11] = {8'h81, 8'h00, 8'h80};
    v[12] = {8'hCC, 8'hAA, 8'h33};  v[13] = {8'h0F, 8'hF0, 8'h33};
    v[14] = {8'h44, 8'h88, 8'h43};  v[15] = {8'h5A, 8'h5A, 8'h53};
    v[16] = {8'h5A, 8'hA5, 8'h53};  v[17] = {8'hFF, 8'h00, 8'h60};
    v[18] = {8'h0F, 8'h00, 8'h60};  v[19] = {8'h00, 8'h00, 8'h43};
    for (int i = 0; i < 20; i++) begin
      if (v[i][7:4] >= 4'h3 && v[i][7:4] <= 4'h6)
        run_op(v[i][23:16], v[i][15:8], v[i][7:0], "R5 logic");
      else
        run_op(v[i][23:16], v[i][15:8], v[i][7:0], "R2 R4 arith");
    end
  endtask

  task automatic t_flagkeep();
    run_op(8'h11, 8'h80, 8'hD3, "R6 copy keeps flags");
    run_op(8'h11, 8'h80, 8'h00, "R6 nop keeps flags");
    run_op(8'h11, 8'h80, 8'hE0, "R6 spare keeps flags");
  endtask

  task automatic t_store();
    int n, w, r;
    begin_prog();
    mem[0] = 8'hB8; mem[1] = 8'h3C;
    mem[8] = 8'h91; mem[9] = 8'hA6; mem[10] = 8'hA7; mem[11] = 8'hF0;
    go();
    run_to_halt(n, w, r);
    chk("R7 store at 6", 32'(mem[6]), 32'h3C);
    chk("R7 store at 7", 32'(mem[7]), 32'h3C);
    chk("R7 write pulses", 32'(w), 32'd2);
    chk("R6 load flags unchanged", 32'(flags_o), 32'h0);
  endtask

  task automatic t_jump();
    int n, w, r;
    begin_prog();
    mem[0] = 8'hB8;
    mem[8] = 8'hBC; mem[9] = 8'h70; mem[10] = 8'h70; mem[11] = 8'h70;
    mem[12] = 8'h70; mem[13] = 8'hF0;
    go();
    run_to_halt(n, w, r);
    chk("R8 skipped bytes not run", 32'(acc_o), 32'h1);
  endtask

  task automatic t_halt();
    int n, w, r, acts;
    begin_prog();
    mem[0] = 8'hF0;
    go();
    run_to_halt(n, w, r);
    chk("R11 halt after five edges", 32'(n), 32'd5);
    acts = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      halt_i = (i % 3 == 0);
      if (mem_rd_o || mem_wr_o || !halted_o) acts = acts + 1;
    end
    halt_i = 1'b0;
    chk("R9 stays halted and quiet", 32'(acts), 32'd0);
    begin_prog();
    chk("R9 reset clears halted", 32'(halted_o), 32'h0);
  endtask

  task automatic t_timing();
    int n, w, r;
    begin_prog();
    mem[0] = 8'h90; mem[1] = 8'hA5; mem[2] = 8'h70; mem[3] = 8'hF0;
    go();
    run_to_halt(n, w, r);
    chk("R11 load+store+inc+halt cycles", 32'(n), 32'd21);
    chk("R6 load value", 32'(mem[5]), 32'h90);
    chk("R4 inc into sign", 32'({flags_o, acc_o}), 32'({3'b100, 8'h91}));
  endtask

  task automatic t_freeze();
    logic [7:0] ref_acc, ref_addr, snap_acc, snap_addr;
    logic       ref_rd, snap_rd, snap_wr;
    logic [2:0] snap_f;
    int         drift;
    begin_prog();
    mem[0] = 8'h70; mem[1] = 8'hB0;
    go();
    repeat (57) @(negedge clk);
    ref_acc = acc_o; ref_addr = mem_addr_o; ref_rd = mem_rd_o;
    chk("R11 loop count", 32'(ref_acc), 32'd6);
    begin_prog();
    mem[0] = 8'h70; mem[1] = 8'hB0;
    go();
    repeat (23) @(negedge clk);
    halt_i = 1'b1;
    snap_acc = acc_o; snap_addr = mem_addr_o; snap_rd = mem_rd_o;
    snap_wr = mem_wr_o; snap_f = flags_o;
    drift = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (acc_o !== snap_acc || mem_addr_o !== snap_addr || mem_rd_o !== snap_rd ||
          mem_wr_o !== snap_wr || flags_o !== snap_f) drift = drift + 1;
    end
    halt_i = 1'b0;
    chk("R10 frozen outputs", 32'(drift), 32'd0);
    repeat (34) @(negedge clk);
    chk("R10 resumed acc",  32'(acc_o),      32'(ref_acc));
    chk("R10 resumed addr", 32'(mem_addr_o), 32'(ref_addr));
    chk("R10 resumed rd",   32'(mem_rd_o),   32'(ref_rd));
  endtask

  initial begin
    t_reset();
    t_fetch();
    t_alu();
    t_flagkeep();
    t_store();
    t_jump();
    t_halt();
    t_timing();
    t_freeze();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule